// File: doc/BRIEF.md
# Raster Line Interrupt Counter

This block raises a processor interrupt when the video side reaches a chosen line of the raster frame. The video side supplies a one-cycle pulse each time a new line is detected, plus a level that is high while rendering is active. Software programs an 8-bit target line and an enable bit, and reads a status byte that reports a pending flag and an in-frame flag.

The block keeps an in-frame flag and an up-counter. The first line pulse after rendering starts opens the frame. It zeroes the counter and drops any stale pending flag. Each later pulse increments the counter, and the incremented value is compared with the target. A match sets the pending flag whether or not the interrupt is enabled. The interrupt line is an active-low level that is driven low only while both pending and enable are set. Reading the status byte acknowledges the interrupt. When rendering stops, at the end of the visible lines or because software switched it off, the frame closes and the next pulse starts counting again from zero. The line pulse arrives near the end of the line before the counted one, so the interrupt lands just ahead of the target line.

Top module: `scanline_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, the status byte reads 0x00 and `irq_n` is 1. The target is 0 and the interrupt is disabled.
- R2: Status bit 7 is the pending flag and status bit 6 is the in-frame flag. Bits 5..0 always read 0.
- R3: A line pulse while rendering is active and in-frame is clear sets in-frame, zeroes the counter and clears pending. The change is visible in the cycle after the pulse.
- R4: A line pulse while in-frame is set increments the counter. If the incremented value equals the target, pending is set in the cycle after the pulse. With target N, pending therefore rises on the N-th pulse after the frame-opening pulse.
- R5: A target of 0 never sets pending, however many line pulses arrive.
- R6: Pending is set by a match even when the interrupt is disabled. `irq_n` is 0 exactly when pending and enable are both set.
- R7: A status read (`rd_stat` high for one cycle) clears pending. `irq_n` returns to 1 in the cycle after the read.
- R8: While `render_on` is low, in-frame is cleared in the next cycle. The next pulse with rendering active restarts the count from 0. Pending is not cleared by rendering stopping.
- R9: If a status read and a counter match fall in the same cycle, pending stays set.
- R10: A write with `wr_sel`=0 loads the 8-bit target. A write with `wr_sel`=1 loads the enable from data bit 7 only; the other data bits are ignored.
- R11: A line pulse while `render_on` is low has no effect on in-frame, the counter or pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_pulse | input | 1 | One-cycle pulse for each detected line |
| render_on | input | 1 | High while the video side is rendering |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write select: 0 for target, 1 for enable |
| wr_data | input | 8 | Write data |
| rd_stat | input | 1 | Status read strobe; acknowledges pending |
| status | output | 8 | Status byte: pending in bit 7, in-frame in bit 6 |
| irq_n | output | 1 | Active-low interrupt request level |

## Verification
Every state change is one register stage away from its cause. A pulse, a write, a read or a drop of `render_on` is applied on one clock edge, and its effect appears on `status` and `irq_n` right after that edge, since both outputs are combinational views of the flags. The bench drives each stimulus on a falling edge, lets one rising edge pass, and compares both outputs at the following falling edge. This holds for every row of the vector table and every directed test. The same-cycle read-and-match case is checked in the cycle right after the shared edge, because a one-cycle-late comparison would hide a lost pending flag.

// File: rtl/scanline_irq_pkg.sv
// Shared constants for the raster line interrupt counter.
// Assumes an 8-bit processor data path for the register port.
package scanline_irq_pkg;
    localparam int DATA_W     = 8;
    localparam int PEND_BIT   = 7;
    localparam int FRAME_BIT  = 6;
    localparam int ENABLE_BIT = 7;
endpackage

// File: rtl/sirq_cfg_regs.sv
// Holds the software-written target line and the interrupt enable.
// Assumes single-cycle write strobes; wr_sel picks the register.
module sirq_cfg_regs #(
    parameter int LINE_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic                                wr_sel,
    input  logic [scanline_irq_pkg::DATA_W-1:0] wr_data,
    output logic [LINE_W-1:0]                   target,
    output logic                                irq_enable
);
    import scanline_irq_pkg::*;

    // Load the target or the enable bit on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target     <= '0;
            irq_enable <= 1'b0;
        end else if (wr_en) begin
            if (wr_sel) irq_enable <= wr_data[ENABLE_BIT];
            else        target     <= wr_data[LINE_W-1:0];
        end
    end
endmodule

// File: rtl/sirq_line_tracker.sv
// Tracks the in-frame flag and the up-counter of lines within the frame.
// Reports a frame-opening event and a post-increment match with the target.
// Assumes line_pulse is a one-cycle pulse; it is ignored while render_on is low.
// The counter is one bit wider than the target and saturates, so that a
// target of 0 can never be matched.
module sirq_line_tracker #(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_pulse,
    input  logic              render_on,
    input  logic [LINE_W-1:0] target,
    output logic              in_frame,
    output logic              frame_open,
    output logic              line_match
);
    localparam int CNT_W = LINE_W + 1;

    logic [CNT_W-1:0] line_cnt;
    logic [CNT_W-1:0] cnt_next;
    logic             live_pulse;

    // Decode the pulse and form the incremented count.
    always_comb begin
        live_pulse = line_pulse && render_on;
        cnt_next   = (line_cnt == {CNT_W{1'b1}}) ? line_cnt : line_cnt + 1'b1;
        frame_open = live_pulse && !in_frame;
        line_match = live_pulse && in_frame && (cnt_next == {1'b0, target});
    end

    // Update the in-frame flag and the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            line_cnt <= '0;
        end else if (!render_on) begin
            in_frame <= 1'b0;
        end else if (frame_open) begin
            in_frame <= 1'b1;
            line_cnt <= '0;
        end else if (live_pulse) begin
            line_cnt <= cnt_next;
        end
    end
endmodule

// File: rtl/sirq_pending.sv
// Pending flag. A match sets it, a frame opening clears it, and a status read
// acknowledges it. A match takes priority over a read in the same cycle.
module sirq_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic line_match,
    input  logic frame_open,
    input  logic rd_stat,
    output logic pending
);
    // Resolve set and clear requests by priority.
    always_ff @(posedge clk) begin
        if (!rst_n)          pending <= 1'b0;
        else if (line_match) pending <= 1'b1;
        else if (frame_open) pending <= 1'b0;
        else if (rd_stat)    pending <= 1'b0;
    end
endmodule

// File: rtl/scanline_irq_unit.sv
// Raster line interrupt counter: top level.
// Connects the configuration registers, the line tracker and the pending flag.
// Drives the status byte and the active-low interrupt level. Both outputs are
// combinational views of registered state.
module scanline_irq_unit #(
    parameter int LINE_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                line_pulse,
    input  logic                                render_on,
    input  logic                                wr_en,
    input  logic                                wr_sel,
    input  logic [scanline_irq_pkg::DATA_W-1:0] wr_data,
    input  logic                                rd_stat,
    output logic [scanline_irq_pkg::DATA_W-1:0] status,
    output logic                                irq_n
);
    import scanline_irq_pkg::*;

    logic [LINE_W-1:0] target;
    logic              irq_enable;
    logic              in_frame;
    logic              frame_open;
    logic              line_match;
    logic              pending;

    sirq_cfg_regs #(.LINE_W(LINE_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .target     (target),
        .irq_enable (irq_enable)
    );

    sirq_line_tracker #(.LINE_W(LINE_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_pulse (line_pulse),
        .render_on  (render_on),
        .target     (target),
        .in_frame   (in_frame),
        .frame_open (frame_open),
        .line_match (line_match)
    );

    sirq_pending u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_match (line_match),
        .frame_open (frame_open),
        .rd_stat    (rd_stat),
        .pending    (pending)
    );

    // Assemble the status byte and the interrupt level.
    always_comb begin
        status            = '0;
        status[PEND_BIT]  = pending;
        status[FRAME_BIT] = in_frame;
        irq_n             = !(pending && irq_enable);
    end
endmodule

// File: rtl/sirq_checker.sv
// Checker for the raster line interrupt counter, bound to the top level.
// Uses only the top-level ports.
module sirq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       line_pulse,
    input logic       render_on,
    input logic       rd_stat,
    input logic [7:0] status,
    input logic       irq_n
);
    // R2: the reserved status bits stay zero.
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status[5:0] == 6'b0);

    // R6: a low interrupt level requires pending.
    p_irq_needs_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> status[7]);

    // R3: a frame-opening pulse sets in-frame and clears pending.
    p_frame_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pulse && render_on && !status[6]) |=> (status[6] && !status[7]));

    // R8: rendering stopped closes the frame.
    p_render_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !render_on |=> !status[6]);

    // R7: a read with no line pulse clears pending and releases the interrupt.
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !line_pulse) |=> (!status[7] && irq_n));

    // R9: pending holds unless it is read or a new frame opens.
    p_pend_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !rd_stat && !(line_pulse && render_on && !status[6])) |=> status[7]);
endmodule

bind scanline_irq_unit sirq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_pulse (line_pulse),
    .render_on  (render_on),
    .rd_stat    (rd_stat),
    .status     (status),
    .irq_n      (irq_n)
);

// File: tb/scanline_irq_unit_tb.sv
// Bench for the raster line interrupt counter: a vector table, then directed tests.
module scanline_irq_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_pulse = 1'b0;
    logic       render_on = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_stat = 1'b0;
    logic [7:0] status;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    scanline_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse), .render_on(render_on),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_stat(rd_stat),
        .status(status), .irq_n(irq_n)
    );

    // Vector: pulse, render, read, write, sel, data[8], exp_status[8], exp_irq_n
    function automatic logic [21:0] vec(input logic pl, input logic ro, input logic rd,
                                        input logic we, input logic sel, input logic [7:0] d,
                                        input logic [7:0] st, input logic irq);
        return {pl, ro, rd, we, sel, d, st, irq};
    endfunction

    localparam int NV = 20;
    localparam logic [21:0] VT [NV] = '{
        vec(0,1,0,1,0,8'h03, 8'h00,1), // R10 target=3
        vec(0,1,0,1,1,8'h80, 8'h00,1), // R10 enable
        vec(1,1,0,0,0,8'h00, 8'h40,1), // R3 frame opens
        vec(1,1,0,0,0,8'h00, 8'h40,1), // R4 count 1
        vec(1,1,0,0,0,8'h00, 8'h40,1), // R4 count 2
        vec(1,1,0,0,0,8'h00, 8'hC0,0), // R4 count 3 match
        vec(0,1,0,0,0,8'h00, 8'hC0,0), // R4 hold
        vec(0,1,1,0,0,8'h00, 8'h40,1), // R7 read acks
        vec(1,1,0,0,0,8'h00, 8'h40,1), // R4 count 4
        vec(0,0,0,0,0,8'h00, 8'h00,1), // R8 render off
        vec(1,0,0,0,0,8'h00, 8'h00,1), // R11 pulse ignored
        vec(1,1,0,0,0,8'h00, 8'h40,1), // R8 restart from 0
        vec(0,1,0,1,1,8'h00, 8'h40,1), // R10 disable
        vec(1,1,0,0,0,8'h00, 8'h40,1), // count 1
        vec(1,1,0,0,0,8'h00, 8'h40,1), // count 2
        vec(1,1,0,0,0,8'h00, 8'hC0,1), // R6 pending while disabled
        vec(0,1,0,1,1,8'h80, 8'hC0,0), // R6 enable raises irq
        vec(1,1,0,0,0,8'h00, 8'hC0,0), // count 4, pending stays
        vec(0,0,0,0,0,8'h00, 8'h80,0), // R8 pending survives render off
        vec(1,1,0,0,0,8'h00, 8'h40,1)  // R3 new frame clears pending
    };

    task automatic check(input string req, input logic [7:0] st_e, input logic irq_e);
        n_chk++;
        if (status !== st_e || irq_n !== irq_e) begin
            n_bad++;
            $display("FAIL %s: status=%02h irq_n=%b expected status=%02h irq_n=%b",
                     req, status, irq_n, st_e, irq_e);
        end
    endtask

    task automatic step(input logic pl, input logic ro, input logic rd,
                        input logic we, input logic sel, input logic [7:0] d);
        line_pulse = pl; render_on = ro; rd_stat = rd;
        wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        line_pulse = 1'b0; rd_stat = 1'b0; wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cyc);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        step(0,1,0,0,0,8'h00);
        rst_n = 1'b1;
        check("R1 reset state", 8'h00, 1'b1);

        for (int i = 0; i < NV; i++) begin
            logic [21:0] v;
            v = VT[i];
            step(v[21], v[20], v[19], v[18], v[17], v[16:9]);
            check($sformatf("vector %0d (R2..R11)", i), v[8:1], v[0]);
        end

        // R5: target 0 never matches, even after many lines.
        step(0,1,0,1,0,8'h00);
        step(0,0,0,0,0,8'h00);
        step(1,1,0,0,0,8'h00);
        for (int k = 0; k < 300; k++) step(1,1,0,0,0,8'h00);
        check("R5 target zero", 8'h40, 1'b1);

        // R9: read in the same cycle as a match keeps pending.
        step(0,1,0,1,0,8'h02);
        step(0,0,0,0,0,8'h00);
        step(1,1,0,0,0,8'h00);
        step(1,1,0,0,0,8'h00);
        check("R4 before match", 8'h40, 1'b1);
        step(1,1,1,0,0,8'h00);
        check("R9 match beats read", 8'hC0, 1'b0);

        // R10: enable depends on bit 7 only.
        step(0,1,0,1,1,8'h7F);
        check("R10 data 7F disables", 8'hC0, 1'b1);
        step(0,1,0,1,1,8'hFF);
        check("R10 data FF enables", 8'hC0, 1'b0);

        // R1: reset in mid-run returns to the idle state.
        rst_n = 1'b0;
        step(0,1,0,0,0,8'h00);
        rst_n = 1'b1;
        check("R1 reset mid run", 8'h00, 1'b1);
        // R1: enable is cleared, so a match does not drive irq.
        step(0,1,0,1,0,8'h01);
        step(1,1,0,0,0,8'h00);
        step(1,1,0,0,0,8'h00);
        check("R1 enable reset to 0", 8'hC0, 1'b1);

        finish_run();
    end
endmodule